// File: doc/BRIEF.md
# Stop-Release Oscillation Stabilization Timer

This block decides how long the processor clock stays held off after the oscillator restarts. Software parks the processor with a stop strobe, and the clock enable falls. When an external wake interrupt arrives, an 8-bit prescaler and an 8-bit timer, chained in cascade, count oscillator cycles. The clock enable returns only when the chain underflows, so the restarting oscillator has time to settle before the processor runs on it.

A control bit selects the preload that is applied at wake. When the bit is clear, the counters are forced to a fixed safe preload: timer 0x01 and prescaler 0xFF, which gives a 512-cycle wait. When the bit is set, the counters keep the timer and prescaler values that software programmed before stopping, and those values set the wait length. Writes made while the processor runs only update the stored values. A countdown starts only on a wake from the stopped state.

Top module: `wakeStabTimer`

## Requirements
- R1: After reset, cpuClkEn is 1, stabDone is 0, autoDis is 0, tmrVal reads 0x01 and preVal reads 0xFF.
- R2: While running, a write with wrEn=1 stores wrData. wrSel 0 writes the timer, wrSel 1 writes the prescaler, wrSel 2 writes wrData bit 0 into autoDis, and wrSel 3 changes nothing. The new value is readable after the write edge.
- R3: A stopReq while running drops cpuClkEn at the next edge. While stopped, the counters hold and register writes are ignored.
- R4: A wake with autoDis=0 loads tmrVal=0x01 and preVal=0xFF at the wake edge, giving a wait of 512 cycles.
- R5: A wake with autoDis=1 keeps the programmed timer value T and prescaler value P, giving a wait of (T+1)*(P+1) cycles.
- R6: During the wait, the prescaler decrements every cycle. When it is zero, it reloads with the value loaded at wake and the timer decrements once.
- R7: cpuClkEn returns to 1, and stabDone pulses for exactly one cycle, on the edge that is the wait length counted from the wake edge.
- R8: After the wait completes, tmrVal and preVal read back the stored programmed values.
- R9: A wakeIrq while running has no effect: cpuClkEn stays 1 and the readback is unchanged.
- R10: During the wait, further wakeIrq or stopReq pulses neither restart nor extend the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopReq | input | 1 | Stop-entry strobe from the processor |
| wakeIrq | input | 1 | External wake interrupt |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Write target: 0 timer, 1 prescaler, 2 control, 3 none |
| wrData | input | 8 | Write data |
| cpuClkEn | output | 1 | Processor clock enable, registered on clk |
| stabDone | output | 1 | One-cycle pulse when stabilization ends |
| autoDis | output | 1 | Control bit readback (1 keeps user values) |
| tmrVal | output | 8 | Timer readback |
| preVal | output | 8 | Prescaler readback |

## Verification
The bench measures the wait in both preload policies. Its boundary cases include a zero prescaler (every cycle is an underflow) and a zero timer with a zero prescaler (the one-cycle wait), which catch an off-by-one in the cascade or the completion decode. Writes during the stop state, wake pulses while running, and stop or wake pulses in the middle of a wait are all aimed at logic that would accept events in the wrong state: such a design would corrupt the programmed wait, gate a running processor, or restart the countdown. The bench also checks the readback after completion, which exposes a design that leaves the auto-preload residue in the counters.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } wstState_e;

  localparam logic [1:0] SEL_TMR = 2'd0;
  localparam logic [1:0] SEL_PRE = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  typedef struct packed {
    logic wrTmr;
    logic wrPre;
    logic wrCtl;
    logic loadAuto;
    logic loadUser;
    logic count;
    logic restore;
  } wstStrb_t;
endpackage

// File: rtl/wstCtrl.sv
module wstCtrl
  import wst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      wakeIrq,
  input  logic      wrEn,
  input  logic [1:0] wrSel,
  input  logic      autoDis,
  input  logic      chainZero,
  output wstStrb_t  strb,
  output wstState_e state,
  output logic      cpuClkEn,
  output logic      stabDone
);
  wstState_e nxt;

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_RUN: begin
        if (wrEn) begin
          case (wrSel)
            SEL_TMR: strb.wrTmr = 1'b1;
            SEL_PRE: strb.wrPre = 1'b1;
            SEL_CTL: strb.wrCtl = 1'b1;
            default: ;
          endcase
        end
        if (stopReq) nxt = ST_STOP;
      end
      ST_STOP: begin
        if (wakeIrq) begin
          nxt = ST_WAIT;
          if (autoDis) strb.loadUser = 1'b1;
          else         strb.loadAuto = 1'b1;
        end
      end
      ST_WAIT: begin
        if (chainZero) begin
          nxt          = ST_RUN;
          strb.restore = 1'b1;
        end else begin
          strb.count = 1'b1;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      cpuClkEn <= 1'b1;
      stabDone <= 1'b0;
    end else begin
      state    <= nxt;
      cpuClkEn <= (nxt == ST_RUN);
      stabDone <= strb.restore;
    end
  end
endmodule

// File: rtl/wstDatapath.sv
module wstDatapath
  import wst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMR_W  = 8,
  parameter int PRE_W  = 8,
  parameter logic [TMR_W-1:0] AUTO_TMR = 8'h01,
  parameter logic [PRE_W-1:0] AUTO_PRE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  wstStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [TMR_W-1:0]  tmrCnt,
  output logic [PRE_W-1:0]  preCnt,
  output logic              autoDis,
  output logic              chainZero
);
  logic [TMR_W-1:0] tmrRld;
  logic [PRE_W-1:0] preRld;
  logic [PRE_W-1:0] preLoad;

  assign chainZero = (tmrCnt == '0) && (preCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrRld  <= AUTO_TMR;
      preRld  <= AUTO_PRE;
      preLoad <= AUTO_PRE;
      tmrCnt  <= AUTO_TMR;
      preCnt  <= AUTO_PRE;
      autoDis <= 1'b0;
    end else begin
      if (strb.wrTmr) begin
        tmrRld <= wrData[TMR_W-1:0];
        tmrCnt <= wrData[TMR_W-1:0];
      end
      if (strb.wrPre) begin
        preRld <= wrData[PRE_W-1:0];
        preCnt <= wrData[PRE_W-1:0];
      end
      if (strb.wrCtl) autoDis <= wrData[0];
      if (strb.loadAuto) begin
        tmrCnt  <= AUTO_TMR;
        preCnt  <= AUTO_PRE;
        preLoad <= AUTO_PRE;
      end
      if (strb.loadUser) begin
        tmrCnt  <= tmrRld;
        preCnt  <= preRld;
        preLoad <= preRld;
      end
      if (strb.count) begin
        if (preCnt == '0) begin
          preCnt <= preLoad;
          tmrCnt <= tmrCnt - 1'b1;
        end else begin
          preCnt <= preCnt - 1'b1;
        end
      end
      if (strb.restore) begin
        tmrCnt <= tmrRld;
        preCnt <= preRld;
      end
    end
  end
endmodule

// File: rtl/wakeStabTimer.sv
module wakeStabTimer
  import wst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMR_W  = 8,
  parameter int PRE_W  = 8,
  parameter logic [TMR_W-1:0] AUTO_TMR = 8'h01,
  parameter logic [PRE_W-1:0] AUTO_PRE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              wakeIrq,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              cpuClkEn,
  output logic              stabDone,
  output logic              autoDis,
  output logic [TMR_W-1:0]  tmrVal,
  output logic [PRE_W-1:0]  preVal
);
  wstStrb_t  strb;
  wstState_e ctrlState;
  logic      chainZero;

  wstCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeIrq(wakeIrq),
    .wrEn(wrEn), .wrSel(wrSel), .autoDis(autoDis), .chainZero(chainZero),
    .strb(strb), .state(ctrlState), .cpuClkEn(cpuClkEn), .stabDone(stabDone)
  );

  wstDatapath #(
    .DATA_W(DATA_W), .TMR_W(TMR_W), .PRE_W(PRE_W),
    .AUTO_TMR(AUTO_TMR), .AUTO_PRE(AUTO_PRE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .tmrCnt(tmrVal), .preCnt(preVal), .autoDis(autoDis), .chainZero(chainZero)
  );
endmodule

// File: rtl/wakeStabTimerChk.sv
module wakeStabTimerChk
  import wst_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PRE_W = 8,
  parameter logic [TMR_W-1:0] AUTO_TMR = 8'h01,
  parameter logic [PRE_W-1:0] AUTO_PRE = 8'hFF
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopReq,
  input logic             wakeIrq,
  input logic             wrEn,
  input logic             cpuClkEn,
  input logic             stabDone,
  input logic             autoDis,
  input logic [TMR_W-1:0] tmrVal,
  input logic [PRE_W-1:0] preVal,
  input wstState_e        ctrlState
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stabDone |=> !stabDone); // R7
  AST_DONE_UNGATES: assert property (@(posedge clk) disable iff (!rstN)
    stabDone |-> cpuClkEn); // R7
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_RUN && stopReq) |=> !cpuClkEn); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_STOP && !wakeIrq) |=> ($stable(tmrVal) && $stable(preVal) && !cpuClkEn)); // R3
  AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_STOP && wakeIrq && !autoDis) |=> (tmrVal == AUTO_TMR && preVal == AUTO_PRE)); // R4
  AST_USER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_STOP && wakeIrq && autoDis) |=> ($stable(tmrVal) && $stable(preVal))); // R5
  AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_WAIT && preVal != '0) |=>
      (tmrVal == $past(tmrVal) && preVal == $past(preVal) - 1'b1)); // R6
  AST_WAKE_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_RUN && wakeIrq && !stopReq && !wrEn) |=>
      (cpuClkEn && $stable(tmrVal) && $stable(preVal))); // R9
endmodule

bind wakeStabTimer wakeStabTimerChk #(
  .TMR_W(TMR_W), .PRE_W(PRE_W), .AUTO_TMR(AUTO_TMR), .AUTO_PRE(AUTO_PRE)
) u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeIrq(wakeIrq), .wrEn(wrEn),
  .cpuClkEn(cpuClkEn), .stabDone(stabDone), .autoDis(autoDis),
  .tmrVal(tmrVal), .preVal(preVal), .ctrlState(ctrlState)
);

// File: tb/wakeStabTimer_bench.sv
module wakeStabTimer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // {autoDis, timer, prescaler, expected wait}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h05, 10'd512},
    {1'b1, 8'h00, 8'h00, 10'd1},
    {1'b1, 8'h00, 8'h03, 10'd4},
    {1'b1, 8'h02, 8'h00, 10'd3},
    {1'b1, 8'h03, 8'h04, 10'd20},
    {1'b1, 8'h01, 8'hFF, 10'd512},
    {1'b1, 8'h0A, 8'h09, 10'd110}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, wakeIrq = 1'b0, wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic cpuClkEn, stabDone, autoDis;
  logic [7:0] tmrVal, preVal;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeStabTimer u_wakeStabTimer (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .wakeIrq(wakeIrq),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .cpuClkEn(cpuClkEn),
    .stabDone(stabDone), .autoDis(autoDis), .tmrVal(tmrVal), .preVal(preVal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic doStop();
    stopReq = 1'b1;
    step();
    stopReq = 1'b0;
    check(cpuClkEn == 1'b0, "R3 clock gated", int'(cpuClkEn), 0);
  endtask

  // wake, then count edges until clock enable returns; pulse wake/stop at pulseAt
  task automatic wakeAndWait(input int pulseAt, output int k, output bit early);
    wakeIrq = 1'b1;
    step();
    wakeIrq = 1'b0;
    k = 0; early = 1'b0;
    while (!cpuClkEn && k < 3000) begin
      if (k == pulseAt) begin wakeIrq = 1'b1; stopReq = 1'b1; end
      step();
      wakeIrq = 1'b0; stopReq = 1'b0;
      k++;
      if (!cpuClkEn && stabDone) early = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    bit early;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(cpuClkEn == 1'b1, "R1 cpuClkEn", int'(cpuClkEn), 1);
    check(stabDone == 1'b0, "R1 stabDone", int'(stabDone), 0);
    check(autoDis == 1'b0, "R1 autoDis", int'(autoDis), 0);
    check(tmrVal == 8'h01, "R1 timer", tmrVal, 8'h01);
    check(preVal == 8'hFF, "R1 prescaler", preVal, 8'hFF);
    rstN = 1'b1;
    step();

    // table walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic a; logic [7:0] t, p, lt, lp, et, ep; int n;
      {a, t, p} = VEC[i][26:10];
      n = int'(VEC[i][9:0]);
      writeReg(2'd2, {7'd0, a});
      writeReg(2'd0, t);
      writeReg(2'd1, p);
      check(autoDis == a && tmrVal == t && preVal == p, "R2 write readback",
            {autoDis, tmrVal, preVal}, {a, t, p});
      doStop();
      wakeIrq = 1'b1;
      step();
      wakeIrq = 1'b0;
      lt = a ? t : 8'h01;
      lp = a ? p : 8'hFF;
      if (a) check(tmrVal == lt && preVal == lp, "R5 user values kept", {tmrVal, preVal}, {lt, lp});
      else   check(tmrVal == lt && preVal == lp, "R4 auto preload", {tmrVal, preVal}, {lt, lp});
      k = 0; early = 1'b0;
      if (n > 1) begin
        step(); k = 1;
        if (lp != 0) begin et = lt; ep = lp - 8'd1; end
        else begin et = lt - 8'd1; ep = lp; end
        check(tmrVal == et && preVal == ep, "R6 cascade step", {tmrVal, preVal}, {et, ep});
      end
      while (!cpuClkEn && k < 3000) begin
        step(); k++;
        if (!cpuClkEn && stabDone) early = 1'b1;
      end
      check(k == n, "R7 wait length", k, n);
      check(stabDone == 1'b1 && !early, "R7 done pulse", int'(stabDone), 1);
      check(tmrVal == t && preVal == p, "R8 restored readback", {tmrVal, preVal}, {t, p});
      step();
      check(stabDone == 1'b0, "R7 pulse one cycle", int'(stabDone), 0);
    end

    // R2: wrSel 3 writes nothing
    writeReg(2'd3, 8'hAA);
    check(tmrVal == 8'h0A && preVal == 8'h09 && autoDis == 1'b1, "R2 wrSel 3 ignored",
          {autoDis, tmrVal, preVal}, {1'b1, 8'h0A, 8'h09});

    // R9: wake while running
    wakeIrq = 1'b1; step(); wakeIrq = 1'b0; step();
    check(cpuClkEn == 1'b1 && tmrVal == 8'h0A && preVal == 8'h09, "R9 wake while running",
          {cpuClkEn, tmrVal, preVal}, {1'b1, 8'h0A, 8'h09});

    // R3: writes during stop ignored
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h02);
    doStop();
    writeReg(2'd0, 8'h40);
    writeReg(2'd2, 8'h00);
    check(tmrVal == 8'h00 && preVal == 8'h02 && autoDis == 1'b1, "R3 stopped write ignored",
          {autoDis, tmrVal, preVal}, {1'b1, 8'h00, 8'h02});
    wakeAndWait(-1, k, early);
    check(k == 3, "R3 wait uses pre-stop values", k, 3);

    // R10: wake and stop pulses mid-wait
    writeReg(2'd0, 8'h01);
    writeReg(2'd1, 8'h04);
    doStop();
    wakeAndWait(3, k, early);
    check(k == 10, "R10 mid-wait pulses ignored", k, 10);
    step();
    check(cpuClkEn == 1'b1, "R10 running after wait", int'(cpuClkEn), 1);

    // R1: reset in the middle of a wait
    doStop();
    wakeIrq = 1'b1; step(); wakeIrq = 1'b0;
    step(); step();
    rstN = 1'b0;
    step();
    check(cpuClkEn == 1'b1 && tmrVal == 8'h01 && preVal == 8'hFF && autoDis == 1'b0,
          "R1 reset mid-wait", {cpuClkEn, autoDis, tmrVal, preVal}, {1'b1, 1'b0, 8'h01, 8'hFF});
    rstN = 1'b1;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule